// File: doc/BRIEF.md
# Five-Step Microcoded 8-Bit Processor

This block is a small 8-bit processor core. Each instruction takes exactly five clock cycles. A step counter runs through the values 0 to 4 and then repeats. During the first four steps a tiny built-in microcode table supplies fixed instructions. These instructions fetch the two bytes of the next program instruction into two dedicated registers and advance the program counter after each byte. In the fifth step the fetched pair runs through the same decoder, register file, adder and memory path that the microcode used. No separate fetch hardware exists.

Memory is a single 8-bit address space. Addresses whose upper nibble is zero read a 16-byte program image, which is a parameter. Every other address goes to a small RAM. The default program image increments a RAM counter at address 0x80 forever. The core's outputs show the step counter, every register and the store strobe, so that a system or a bench can follow execution.

Top module: `micro8_core`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears all eight registers, the step counter and every RAM byte to zero, and holds them there while it is asserted.
- R2: The step counter advances by one on each rising clock edge, from 0 up to 4, and returns from 4 to 0.
- R3: In steps 0 and 2 the byte at the address held in the program counter (register 7) is loaded into register 5 and register 6 respectively. In steps 1 and 3 the program counter increments by one. The microcode pairs (low/high) for steps 0 to 3 are a1/07, e2/01, c1/07 and e2/01.
- R4: In step 4 the instruction is formed from register 5 (low byte) and register 6 (high byte). Low byte: bit 0 = memory access, bit 1 = immediate mode, bit 2 = store, bits 4:3 = function, bits 7:5 = destination select. High byte: bits 2:0 = first source select, bits 5:3 = second source select; the whole high byte is also the immediate.
- R5: In immediate mode the first ALU operand is the high byte and the second is the register named by the destination select. Otherwise the operands are the registers named by the two source selects.
- R6: With function 0 the ALU result is the operand sum modulo 256. Any other function value yields 0. A non-memory instruction writes the result to the destination register.
- R7: An address whose bits 7:4 are all zero reads program byte [3:0]. Any other address reads and writes RAM.
- R8: A load (memory bit 1, store bit 0) writes the byte at the address held in the first-source register into the destination register.
- R9: A store (memory bit 1, store bit 1) writes the second-source register to the address held in the first-source register. It asserts `st_en_o` with that address and data and changes no register. A store into the program range leaves the program bytes unchanged.
- R10: With the default program the byte at RAM address 0x80 is stored as 1, 2, 3, ... on successive passes of the loop. At the end of each pass the program counter moves back from 10 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_o | output | 3 | Current step of the five-step instruction cycle |
| regs_o | output | 64 | All registers; register i is at bits [8i+7:8i] |
| st_en_o | output | 1 | Store being performed this cycle |
| st_addr_o | output | 8 | Store address |
| st_data_o | output | 8 | Store data |

## Verification
Two functions compete for the same cycle in two situations. In step 4 a store and a register write-back share the one decoded instruction, and a store to the RAM at 0x80 reads and writes memory on the same edge that would otherwise update a register. The bench runs store instructions with a nonzero destination field and checks that the store appears at the ports with the right address and data, that no register changes across that edge, and that a later load returns the stored value. A store aimed at the program range is followed by a load of that address, which must return the original program byte.

// File: rtl/micro8_pkg.sv
package micro8_pkg;

   localparam int WORD_W  = 8;
   localparam int SEL_W   = 3;
   localparam int N_STEPS = 5;
   localparam int STEP_W  = 3;
   localparam logic [STEP_W-1:0] EXEC_STEP = 3'd4;

   localparam logic [SEL_W-1:0] IDX_LO = 3'd5;
   localparam logic [SEL_W-1:0] IDX_HI = 3'd6;
   localparam logic [SEL_W-1:0] IDX_PC = 3'd7;

   typedef struct packed {
      logic [SEL_W-1:0] dst;
      logic [1:0]       fn;
      logic             st;
      logic             imm;
      logic             mem;
   } lo_byte_t;

   typedef struct packed {
      logic [1:0]       spare;
      logic [SEL_W-1:0] src_d;
      logic [SEL_W-1:0] src_a;
   } hi_byte_t;

   typedef struct packed {
      logic [SEL_W-1:0]  sel_a;
      logic [SEL_W-1:0]  sel_d;
      logic [SEL_W-1:0]  sel_w;
      logic              reg_we;
      logic              mem_rd;
      logic              mem_st;
      logic              use_imm;
      logic [1:0]        fn;
      logic [WORD_W-1:0] imm_val;
   } ctrl_t;

   function automatic logic [2*WORD_W-1:0] ucode_word(input logic [STEP_W-1:0] s);
      logic [2*WORD_W-1:0] w;
      case (s)
         3'd0:    w = {8'h07, 8'ha1};
         3'd1:    w = {8'h01, 8'he2};
         3'd2:    w = {8'h07, 8'hc1};
         default: w = {8'h01, 8'he2};
      endcase
      return w;
   endfunction

   function automatic ctrl_t decode(input logic [WORD_W-1:0] lo_raw,
                                    input logic [WORD_W-1:0] hi_raw);
      lo_byte_t l;
      hi_byte_t h;
      ctrl_t    c;
      l = lo_byte_t'(lo_raw);
      h = hi_byte_t'(hi_raw);
      c.sel_a   = h.src_a;
      c.sel_d   = l.imm ? l.dst : h.src_d;
      c.sel_w   = l.dst;
      c.mem_rd  = l.mem;
      c.mem_st  = l.mem & l.st;
      c.reg_we  = ~(l.mem & l.st);
      c.use_imm = l.imm;
      c.fn      = l.fn;
      c.imm_val = hi_raw;
      return c;
   endfunction

endpackage

// File: rtl/micro8_seq.sv
module micro8_seq #(
   parameter int STEPS = 5,
   parameter int SW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [SW-1:0] step
);
   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   if (STEPS < 2 || STEPS > (1 << SW)) begin : g_bad_steps
      $error("micro8_seq: STEPS does not fit the counter width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            step <= '0;
      else if (step == LAST) step <= '0;
      else                   step <= step + 1'b1;
   end
endmodule

// File: rtl/micro8_regfile.sv
module micro8_regfile #(
   parameter int DW   = 8,
   parameter int NREG = 8,
   localparam int SW  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SW-1:0]      rsel_a,
   input  logic [SW-1:0]      rsel_d,
   output logic [DW-1:0]      rdat_a,
   output logic [DW-1:0]      rdat_d,
   input  logic               we,
   input  logic [SW-1:0]      wsel,
   input  logic [DW-1:0]      wdat,
   output logic [NREG*DW-1:0] flat
);
   logic [DW-1:0] r [NREG];

   if (NREG != (1 << SW)) begin : g_bad_nreg
      $error("micro8_regfile: NREG must be a power of two");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         r[i] <= '0;
         else if (we && wsel == SW'(i))      r[i] <= wdat;
      end
      assign flat[i*DW +: DW] = r[i];
   end

   assign rdat_a = r[rsel_a];
   assign rdat_d = r[rsel_d];
endmodule

// File: rtl/micro8_alu.sv
module micro8_alu #(
   parameter int DW = 8
) (
   input  logic [1:0]    fn,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_d,
   output logic [DW-1:0] res
);
   always_comb begin
      if (fn == 2'd0) res = op_a + op_d;
      else            res = '0;
   end
endmodule

// File: rtl/micro8_mem.sv
module micro8_mem #(
   parameter int DW        = 8,
   parameter int ROM_AW    = 4,
   parameter int RAM_DEPTH = 16,
   parameter logic [(DW<<ROM_AW)-1:0] PROG = '0,
   localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] addr,
   input  logic          wr,
   input  logic [DW-1:0] wdat,
   output logic [DW-1:0] rdat
);
   logic          hit_ram;
   logic [DW-1:0] rom_q;
   logic [DW-1:0] ram_q;

   if (RAM_DEPTH < 2 || RAM_DEPTH != (1 << RAM_AW) || RAM_AW > DW) begin : g_bad_ram
      $error("micro8_mem: RAM_DEPTH must be a power of two within the address range");
   end
   if (ROM_AW >= DW) begin : g_bad_rom
      $error("micro8_mem: program range must leave upper address bits");
   end

   assign hit_ram = |addr[DW-1:ROM_AW];
   assign rom_q   = PROG[addr[ROM_AW-1:0]*DW +: DW];

   logic [DW-1:0] ram [RAM_DEPTH];
   logic [RAM_AW-1:0] ridx;
   assign ridx  = addr[RAM_AW-1:0];
   assign ram_q = ram[ridx];

   for (genvar i = 0; i < RAM_DEPTH; i++) begin : g_ram
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    ram[i] <= '0;
         else if (wr && hit_ram && ridx == RAM_AW'(i))  ram[i] <= wdat;
      end
   end

   assign rdat = hit_ram ? ram_q : rom_q;
endmodule

// File: rtl/micro8_core.sv
module micro8_core
   import micro8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NREG      = 8,
   parameter int ROM_AW    = 4,
   parameter int RAM_DEPTH = 16,
   parameter logic [(DATA_W<<ROM_AW)-1:0] PROG = 128'h0000_0000_0000_f8e2_0105_0102_0101_8022
) (
   input  logic                   clk,
   input  logic                   rst_n,
   output logic [2:0]             step_o,
   output logic [NREG*DATA_W-1:0] regs_o,
   output logic                   st_en_o,
   output logic [DATA_W-1:0]      st_addr_o,
   output logic [DATA_W-1:0]      st_data_o
);
   localparam int SW = $clog2(NREG);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("micro8_core: the instruction encoding fixes an 8-bit word");
   end
   if (NREG != (1 << SEL_W)) begin : g_bad_regs
      $error("micro8_core: the encoding selects exactly eight registers");
   end

   logic [STEP_W-1:0]   step;
   logic [DATA_W-1:0]   insn_lo, insn_hi;
   logic [2*DATA_W-1:0] ucode;
   ctrl_t               ctl;
   logic [DATA_W-1:0]   rd_a, rd_d, op_a, alu_q, mem_q, wb;

   micro8_seq #(.STEPS(N_STEPS), .SW(STEP_W)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .step (step)
   );

   assign insn_lo = regs_o[IDX_LO*DATA_W +: DATA_W];
   assign insn_hi = regs_o[IDX_HI*DATA_W +: DATA_W];
   assign ucode   = ucode_word(step);

   always_comb begin
      if (step == EXEC_STEP) ctl = decode(insn_lo, insn_hi);
      else                   ctl = decode(ucode[DATA_W-1:0], ucode[2*DATA_W-1:DATA_W]);
   end

   micro8_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .rsel_a(SW'(ctl.sel_a)),
      .rsel_d(SW'(ctl.sel_d)),
      .rdat_a(rd_a),
      .rdat_d(rd_d),
      .we    (ctl.reg_we),
      .wsel  (SW'(ctl.sel_w)),
      .wdat  (wb),
      .flat  (regs_o)
   );

   assign op_a = ctl.use_imm ? ctl.imm_val : rd_a;

   micro8_alu #(.DW(DATA_W)) u_alu (
      .fn  (ctl.fn),
      .op_a(op_a),
      .op_d(rd_d),
      .res (alu_q)
   );

   micro8_mem #(.DW(DATA_W), .ROM_AW(ROM_AW), .RAM_DEPTH(RAM_DEPTH), .PROG(PROG)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (rd_a),
      .wr   (ctl.mem_st),
      .wdat (rd_d),
      .rdat (mem_q)
   );

   assign wb        = ctl.mem_rd ? mem_q : alu_q;
   assign step_o    = step;
   assign st_en_o   = ctl.mem_st;
   assign st_addr_o = rd_a;
   assign st_data_o = rd_d;
endmodule

// File: rtl/micro8_core_chk.sv
module micro8_core_chk #(
   parameter int DATA_W = 8,
   parameter int NREG   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [2:0]             step_o,
   input logic [NREG*DATA_W-1:0] regs_o,
   input logic                   st_en_o
);
   logic [DATA_W-1:0] pc;
   assign pc = regs_o[(NREG-1)*DATA_W +: DATA_W];

   assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o <= 3'd4);
   assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o == 3'd4 |=> step_o == 3'd0);
   assert_step_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o < 3'd4 |=> step_o == $past(step_o) + 3'd1);
   assert_pc_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == 3'd1 || step_o == 3'd3) |=> pc == $past(pc) + 1'b1);
   assert_pc_hold_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == 3'd0 || step_o == 3'd2) |=> pc == $past(pc));
   assert_store_exec_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_en_o |-> step_o == 3'd4);
   assert_store_no_regwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_en_o |=> regs_o == $past(regs_o));
endmodule

bind micro8_core micro8_core_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .step_o (step_o),
   .regs_o (regs_o),
   .st_en_o(st_en_o)
);

// File: tb/tb_micro8_core.sv
module tb_micro8_core;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [2:0]  step_a, step_b;
   logic [63:0] regs_a, regs_b;
   logic        st_a, st_b;
   logic [7:0]  sadr_a, sdat_a, sadr_b, sdat_b;

   int checks = 0;
   int errors = 0;
   int done_edges = 0;
   bit finished = 0;

   micro8_core dut (
      .clk(clk), .rst_n(rst_n), .step_o(step_a), .regs_o(regs_a),
      .st_en_o(st_a), .st_addr_o(sadr_a), .st_data_o(sdat_a)
   );

   // second program: 42 05 60 12 68 12 85 13 81 03 e2 fe
   micro8_core #(.PROG(128'h0000_0000_fee2_0381_1385_1268_1260_0542)) dut_b (
      .clk(clk), .rst_n(rst_n), .step_o(step_b), .regs_o(regs_b),
      .st_en_o(st_b), .st_addr_o(sadr_b), .st_data_o(sdat_b)
   );

   function automatic logic [7:0] rg(input logic [63:0] f, input int i);
      return f[i*8 +: 8];
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // advance until edge number e (0 = first edge after reset release) has passed
   task automatic adv(input int e);
      while (done_edges < e + 1) begin
         @(posedge clk);
         done_edges++;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < 8; i++) chk("R1", "reg cleared", rg(regs_a, i), 0);
      chk("R1", "step cleared", step_a, 0);
      chk("R1", "no store in reset", st_a, 0);
      rst_n = 1'b1;
      done_edges = 0;
   endtask

   task automatic t_fetch();
      adv(0);
      chk("R3", "step0 loads low byte", rg(regs_a, 5), 8'h22);
      chk("R2", "step after edge 0", step_a, 1);
      adv(1);
      chk("R3", "step1 increments pc", rg(regs_a, 7), 1);
      adv(2);
      chk("R3", "step2 loads high byte", rg(regs_a, 6), 8'h80);
      adv(3);
      chk("R3", "step3 increments pc", rg(regs_a, 7), 2);
      adv(4);
      chk("R2", "step wraps to 0", step_a, 0);
      chk("R5", "imm add to r1", rg(regs_a, 1), 8'h80);
      chk("R5", "imm write r2 in prog b", rg(regs_b, 2), 5);
   endtask

   task automatic t_alu_modes();
      adv(9);
      chk("R5", "register-mode add r3=r2+r2", rg(regs_b, 3), 10);
      chk("R8", "load from cleared RAM 0x80", rg(regs_a, 0), 0);
      adv(14);
      chk("R6", "nonzero function gives 0", rg(regs_b, 3), 0);
      chk("R6", "increment r0", rg(regs_a, 0), 1);
   endtask

   task automatic t_store();
      adv(18);
      chk("R9", "store strobe", st_a, 1);
      chk("R9", "store address", sadr_a, 8'h80);
      chk("R9", "store data", sdat_a, 1);
      chk("R4", "prog b store strobe", st_b, 1);
      chk("R4", "prog b store address from r3", sadr_b, 0);
      chk("R4", "prog b store data from r2", sdat_b, 5);
      adv(19);
      chk("R9", "store leaves r0", rg(regs_a, 0), 1);
      chk("R9", "store leaves dst r4", rg(regs_b, 4), 0);
      chk("R9", "pc after store fetch", rg(regs_a, 7), 8);
      adv(24);
      chk("R7", "program byte survives store", rg(regs_b, 4), 8'h42);
      chk("R10", "pc wraps back to 2", rg(regs_a, 7), 2);
      adv(29);
      chk("R7", "RAM read back at 0x80", rg(regs_a, 0), 1);
      chk("R5", "prog b jump back", rg(regs_b, 7), 10);
   endtask

   task automatic t_loop();
      for (int k = 2; k <= 6; k++) begin
         adv(19 + 20*(k-1) - 1);
         chk("R10", "store strobe in pass", st_a, 1);
         chk("R10", "stored counter", sdat_a, k);
         adv(24 + 20*(k-1));
         chk("R10", "pc wrap per pass", rg(regs_a, 7), 2);
      end
   endtask

   task automatic t_reset_ram();
      do_reset();
      adv(18);
      chk("R1", "RAM cleared by reset", sdat_a, 1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      do_reset();
      t_fetch();
      t_alu_modes();
      t_store();
      t_loop();
      t_reset_ram();
      finish_run();
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule